// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block collects the four interrupt pins (A to D, pin index 0 to 3) of every PCI slot on a host bridge, folds them onto four shared interrupt lines, and then steers each shared line to one input of a programmable interrupt controller. Slots that sit in a rotating range have their pins rotated by slot position, so that single-function cards, which all use pin 0, spread over different lines. Slots outside that range map their pins straight through. On-board devices wired to fixed lines feed those lines directly.

Each shared line has an 8-bit routing entry. Bit 7 of the entry parks the line (it drives nothing). Bits 3:0 name the controller input the line drives. Bits 6:4 are spare. Every controller input carries the OR of all enabled lines whose entry names it. The controller request lines are registered.

Top module: `pci_irq_router`

## Requirements
- R1: After a synchronous reset every routing entry is parked (bit 7 set) and every `pic_irq` bit is 0. This holds while slot pins and on-board requests are active, until an entry is written.
- R2: For a slot whose number (device/function value shifted right by 3, slot i having device/function `FIRST_DEVFN + 8*i`, so slot numbers 16 to 23 by default) lies in 18 to 21, pin n (bit `4*i+n` of `slot_pins`) drives shared line ((slot - 18) + n) & 3.
- R3: For a slot outside 18 to 21, pin n drives shared line n.
- R4: On-board request d drives the fixed line held in bits [2d+1:2d] of `ONBOARD_LINES`. By default device 0 drives line 2 and device 1 drives line 3.
- R5: A shared line is active whenever any pin or on-board request mapped to it is active (wired OR).
- R6: A write with `route_we` high loads `route_data` into the entry for line `route_sel`. While bit 7 is clear, the line drives controller input bits 3:0. Bits 6:4 have no effect.
- R7: While bit 7 of a line's entry is set, that line sets no `pic_irq` bit.
- R8: A controller input is the OR of every enabled line whose entry names it.
- R9: `pic_irq` is registered. A change at the inputs appears at the first rising clock edge after the change and not before.
- R10: A routing write takes effect on `pic_irq` one edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_pins | input | 4*NUM_SLOTS (32) | Pin levels, slot i pin n at bit 4*i+n |
| onboard_irq | input | NUM_ONBOARD (2) | Fixed-line on-board device requests |
| route_we | input | 1 | Routing entry write strobe |
| route_sel | input | 2 | Shared line whose entry is written |
| route_data | input | 8 | New entry: bit 7 park, bits 3:0 target |
| pic_irq | output | NUM_PIC (16) | Registered controller request lines |

## Verification
The bench first drives a single pin at a time: pin 0 on each rotating slot, then other pins on rotating and direct slots, with each line routed to a different controller input. A wrong rotation, a wrong direct mapping or a wrong on-board line therefore lights a different output bit. Further patterns assert two sources on one line and then drop one of them, to separate wired OR from last-writer behaviour. Routing patterns cover an entry with spare bits set, a parked line, and two lines sharing one target. A final sweep of mixed multi-slot patterns is compared against a reference model. One check samples just after an input change and before the next edge, to confirm that the output is registered.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int LINES  = 4;
    localparam int PINS   = 4;
    localparam int LINE_W = 2;
    localparam int TGT_W  = 4;

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        logic             park;
        logic [2:0]       spare;
        logic [TGT_W-1:0] target;
    } route_entry_t;

    localparam route_entry_t ENTRY_PARKED = '{park: 1'b1, spare: 3'd0, target: '0};

    function automatic int slot_of_devfn(input int devfn);
        return devfn >>> 3;
    endfunction

    function automatic logic [LINE_W-1:0] line_of_pin(input int slot, input int pin,
                                                      input int rot_lo, input int rot_n);
        if (slot >= rot_lo && slot < rot_lo + rot_n)
            return LINE_W'((slot - rot_lo + pin) & (LINES - 1));
        return LINE_W'(pin);
    endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS   = 8,
    parameter int FIRST_DEVFN = 128,
    parameter int ROT_LO      = 18,
    parameter int ROT_N       = 4,
    parameter int NUM_ONBOARD = 2,
    parameter logic [2*NUM_ONBOARD-1:0] ONBOARD_LINES = 4'b11_10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SLOTS*PINS-1:0] slot_pins,
    input  logic [NUM_ONBOARD-1:0]    onboard_irq,
    output line_vec_t                 line_lvl
);

    line_vec_t slot_vec [NUM_SLOTS];
    line_vec_t ob_vec   [NUM_ONBOARD];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int SLOT = slot_of_devfn(FIRST_DEVFN + 8 * s);
        localparam bit ROTATES = (SLOT >= ROT_LO) && (SLOT < ROT_LO + ROT_N);

        always_comb begin
            slot_vec[s] = '0;
            for (int p = 0; p < PINS; p++)
                slot_vec[s][line_of_pin(SLOT, p, ROT_LO, ROT_N)] |= slot_pins[s*PINS + p];
        end

        if (ROTATES) begin : g_rot_chk
            localparam int L0 = (SLOT - ROT_LO) & (LINES - 1);
            assert_rotate_R2: assert property (@(posedge clk) disable iff (rst)
                slot_pins[s*PINS] |-> line_lvl[L0]);
        end else begin : g_dir_chk
            assert_direct_R3: assert property (@(posedge clk) disable iff (rst)
                slot_pins[s*PINS + 3] |-> line_lvl[3]);
        end
    end

    for (genvar d = 0; d < NUM_ONBOARD; d++) begin : g_onboard
        localparam logic [LINE_W-1:0] FIXED = ONBOARD_LINES[2*d +: 2];
        always_comb begin
            ob_vec[d]        = '0;
            ob_vec[d][FIXED] = onboard_irq[d];
        end
    end

    always_comb begin
        line_lvl = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            line_lvl |= slot_vec[s];
        for (int d = 0; d < NUM_ONBOARD; d++)
            line_lvl |= ob_vec[d];
    end

    assert_wired_or_R5: assert property (@(posedge clk) disable iff (rst)
        ((|slot_pins) || (|onboard_irq)) |-> (|line_lvl));

endmodule

// File: rtl/pirq_route_table.sv
module pirq_route_table
    import pirq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [LINE_W-1:0]          wr_sel,
    input  logic [7:0]                 wr_data,
    output route_entry_t [LINES-1:0]   table_q
);

    for (genvar j = 0; j < LINES; j++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                table_q[j] <= ENTRY_PARKED;
            else if (wr_en && wr_sel == LINE_W'(j))
                table_q[j] <= route_entry_t'(wr_data);
        end

        assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == LINE_W'(j)) |=> (table_q[j] == route_entry_t'($past(wr_data))));
    end

endmodule

// File: rtl/pirq_fanin.sv
module pirq_fanin
    import pirq_pkg::*;
#(
    parameter int NUM_PIC = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  line_vec_t                line_lvl,
    input  route_entry_t [LINES-1:0] table_q,
    output logic [NUM_PIC-1:0]       pic_q
);

    logic [NUM_PIC-1:0] pic_d;

    for (genvar k = 0; k < NUM_PIC; k++) begin : g_pic
        always_comb begin
            pic_d[k] = 1'b0;
            for (int j = 0; j < LINES; j++)
                pic_d[k] |= line_lvl[j] && !table_q[j].park &&
                            (table_q[j].target == TGT_W'(k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pic_q <= '0;
        else     pic_q <= pic_d;
    end

    // checks
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d === 1'b1)
            assert_reset_clear_R1: assert (pic_q == '0);
    end

    logic all_parked;
    always_comb begin
        all_parked = 1'b1;
        for (int j = 0; j < LINES; j++)
            all_parked &= table_q[j].park;
    end

    assert_parked_silent_R7: assert property (@(posedge clk) disable iff (rst)
        all_parked |=> (pic_q == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (line_lvl == '0) |=> (pic_q == '0));

    for (genvar j = 0; j < LINES; j++) begin : g_line_chk
        logic [TGT_W-1:0] tgt_q;
        always_ff @(posedge clk) tgt_q <= table_q[j].target;

        assert_routed_line_R8: assert property (@(posedge clk) disable iff (rst)
            (line_lvl[j] && !table_q[j].park && (int'(table_q[j].target) < NUM_PIC))
            |=> pic_q[tgt_q]);
    end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pirq_pkg::*;
#(
    parameter int NUM_SLOTS   = 8,
    parameter int FIRST_DEVFN = 128,
    parameter int ROT_LO      = 18,
    parameter int ROT_N       = 4,
    parameter int NUM_ONBOARD = 2,
    parameter logic [2*NUM_ONBOARD-1:0] ONBOARD_LINES = 4'b11_10,
    parameter int NUM_PIC     = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SLOTS*PINS-1:0] slot_pins,
    input  logic [NUM_ONBOARD-1:0]    onboard_irq,
    input  logic                      route_we,
    input  logic [LINE_W-1:0]         route_sel,
    input  logic [7:0]                route_data,
    output logic [NUM_PIC-1:0]        pic_irq
);

    line_vec_t                line_lvl;
    route_entry_t [LINES-1:0] table_q;

    pirq_swizzle #(
        .NUM_SLOTS    (NUM_SLOTS),
        .FIRST_DEVFN  (FIRST_DEVFN),
        .ROT_LO       (ROT_LO),
        .ROT_N        (ROT_N),
        .NUM_ONBOARD  (NUM_ONBOARD),
        .ONBOARD_LINES(ONBOARD_LINES)
    ) u_swizzle (
        .clk        (clk),
        .rst        (rst),
        .slot_pins  (slot_pins),
        .onboard_irq(onboard_irq),
        .line_lvl   (line_lvl)
    );

    pirq_route_table u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (route_we),
        .wr_sel (route_sel),
        .wr_data(route_data),
        .table_q(table_q)
    );

    pirq_fanin #(.NUM_PIC(NUM_PIC)) u_fanin (
        .clk     (clk),
        .rst     (rst),
        .line_lvl(line_lvl),
        .table_q (table_q),
        .pic_q   (pic_irq)
    );

endmodule

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb_top;

    localparam int NS = 8;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS*4-1:0] slot_pins = '0;
    logic [1:0]    onboard_irq = '0;
    logic          route_we = 1'b0;
    logic [1:0]    route_sel = '0;
    logic [7:0]    route_data = '0;
    logic [NP-1:0] pic_irq;

    int checks = 0;
    int failures = 0;

    logic [7:0]    m_tbl [4];
    logic [NP-1:0] exp_q [$];
    string         tag_q [$];
    logic [NP-1:0] last_exp = '0;

    always #5 clk = ~clk;

    pci_irq_router dut_i (
        .clk(clk), .rst(rst), .slot_pins(slot_pins), .onboard_irq(onboard_irq),
        .route_we(route_we), .route_sel(route_sel), .route_data(route_data),
        .pic_irq(pic_irq)
    );

    function automatic logic [NP-1:0] model(input logic [NS*4-1:0] pins, input logic [1:0] ob);
        logic [3:0] lines = '0;
        logic [NP-1:0] r = '0;
        for (int s = 0; s < NS; s++) begin
            int slot = 16 + s;
            for (int n = 0; n < 4; n++) begin
                int ln = (slot >= 18 && slot <= 21) ? (((slot - 18) + n) & 3) : n;
                if (pins[4*s+n]) lines[ln] = 1'b1;
            end
        end
        if (ob[0]) lines[2] = 1'b1;
        if (ob[1]) lines[3] = 1'b1;
        for (int j = 0; j < 4; j++)
            if (lines[j] && !m_tbl[j][7]) r[m_tbl[j][3:0]] = 1'b1;
        return r;
    endfunction

    task automatic check(input logic [NP-1:0] act, input logic [NP-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: pic_irq=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [NS*4-1:0] pins, input logic [1:0] ob, input string tag);
        @(negedge clk);
        slot_pins   = pins;
        onboard_irq = ob;
        last_exp    = model(pins, ob);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    task automatic write_route(input int line, input logic [7:0] val);
        @(negedge clk);
        route_we   = 1'b1;
        route_sel  = 2'(line);
        route_data = val;
        @(posedge clk);
        #1;
        route_we = 1'b0;
        m_tbl[line] = val;
    endtask

    function automatic logic [NS*4-1:0] pin_bit(input int slot, input int n);
        logic [NS*4-1:0] v = '0;
        v[4*(slot-16)+n] = 1'b1;
        return v;
    endfunction

    // monitor: compares one edge after each driven pattern
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0)
                check(pic_irq, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog: pic_irq=%h expected=end of test", pic_irq);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int j = 0; j < 4; j++) m_tbl[j] = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(pic_irq, '0, "R1 after reset");

        // R1: all parked, everything active
        drive('1, 2'b11, "R1 parked entries");

        // distinct targets per line
        write_route(0, 8'h03);
        write_route(1, 8'h05);
        write_route(2, 8'h09);
        write_route(3, 8'h0C);

        drive(pin_bit(18, 0), 2'b00, "R2 slot18 pin0 -> line0");
        drive(pin_bit(19, 0), 2'b00, "R2 slot19 pin0 -> line1");
        drive(pin_bit(21, 3), 2'b00, "R2 slot21 pin3 -> line2");
        drive(pin_bit(20, 1), 2'b00, "R2 slot20 pin1 -> line3");
        drive(pin_bit(16, 2), 2'b00, "R3 slot16 pin2 -> line2");
        drive(pin_bit(23, 1), 2'b00, "R3 slot23 pin1 -> line1");
        drive(pin_bit(17, 3), 2'b00, "R3 slot17 pin3 -> line3");
        drive('0, 2'b01, "R4 onboard0 -> line2");
        drive('0, 2'b10, "R4 onboard1 -> line3");

        // R5: two sources on line0, drop one
        drive(pin_bit(18, 0) | pin_bit(16, 0), 2'b00, "R5 two sources line0");
        drive(pin_bit(16, 0), 2'b00, "R5 one source left");

        // R9: output still old right after input change
        @(negedge clk);
        slot_pins = pin_bit(19, 0);
        #1;
        check(pic_irq, last_exp, "R9 no change before edge");
        last_exp = model(slot_pins, onboard_irq);
        exp_q.push_back(last_exp);
        tag_q.push_back("R9 change after edge");

        // R6: spare bits ignored
        write_route(0, 8'h77);
        drive(pin_bit(18, 0), 2'b00, "R6 spare bits ignored target7");

        // R7 / R10: park line1 and observe on the next edge
        write_route(1, 8'h85);
        drive(pin_bit(19, 0), 2'b00, "R7 parked line silent (R10 write visible)");
        drive('1, 2'b11, "R7 parked line with all active");

        // R8: lines 0 and 2 share target 7
        write_route(2, 8'h07);
        drive(pin_bit(18, 0), 2'b00, "R8 shared target from line0");
        drive(pin_bit(21, 3), 2'b00, "R8 shared target from line2");
        drive(pin_bit(18, 0) | pin_bit(21, 3), 2'b00, "R8 shared target both");
        drive('0, 2'b00, "R8 shared target none");

        // mixed patterns
        write_route(1, 8'h01);
        for (int i = 0; i < 24; i++) begin
            logic [NS*4-1:0] p = NS*4'((i * 32'h9E3779B1) >> (i % 7));
            drive(p & {8{4'(i)}}, 2'(i), "R2 R3 mixed pattern");
        end

        drive('0, 2'b00, "R9 idle");
        repeat (3) @(posedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule